// File: doc/BRIEF.md
# Retirement Progress and Index Uniqueness Monitor

This block watches a single-channel instruction retirement trace and judges two rules about one chosen instruction. When `trigger` is high in a cycle that retires an instruction, that instruction's order index becomes the reference K. Two checks follow from then on. The first is a progress check: the instruction with index K+1 must retire before the verdict cycle, unless the reference instruction retired with its halt flag set. The second is a uniqueness check: no later retirement may carry index K again.

The environment holds `rst` high for a first phase and then releases it for a window of cycles. It raises `trigger` once somewhere inside that window and raises `check` on the last cycle, where the progress verdict is read. A uniqueness violation is flagged in the cycle the repeated index appears and stays flagged until reset. Retirements before the trigger play no part in either rule. The block does not look at instruction encodings, register values or memory data.

Top module: `retire_progress_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, both `live_ok` and `uniq_ok` are 1.
- R2: Only the first cycle with `trigger` and `trace_valid` both high captures the reference index K and halt flag. A trigger in a cycle with `trace_valid` low captures nothing, and later triggers are ignored.
- R3: `live_ok` is 1 in the `check` cycle if a retirement with index K+1 happened after the trigger cycle, up to and including the `check` cycle itself.
- R4: `live_ok` is 0 in the `check` cycle if a reference was captured without halt and no retirement with index K+1 has followed it.
- R5: If the reference retired with `trace_halt` = 1, `live_ok` stays 1 even without a K+1 retirement. A halt flag on any other retirement waives nothing.
- R6: `live_ok` is 1 in every cycle where `check` is 0.
- R7: A retirement with index K after the trigger cycle drives `uniq_ok` to 0 in that same cycle, and it stays 0 until reset.
- R8: Retirements before the trigger cycle, including ones that carry K or K+1, affect neither flag.
- R9: If no reference was captured, both flags are 1 in the `check` cycle.
- R10: K+1 is computed modulo 2^ORD_W, so when K is all ones the successor index is 0.
- R11: `trace_order` and `trace_halt` are ignored in cycles where `trace_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the monitor |
| trace_valid | input | 1 | An instruction retires this cycle |
| trace_order | input | ORD_W (64) | Order index of the retiring instruction |
| trace_halt | input | 1 | The retiring instruction halts the core |
| trigger | input | 1 | Select the retiring instruction as reference |
| check | input | 1 | Verdict cycle for the progress rule |
| live_ok | output | 1 | Progress rule holds (1) or fails (0) |
| uniq_ok | output | 1 | Uniqueness rule holds (1) or fails (0) |

## Verification
A sweep moves the trigger cycle, the cycle of the successor retirement and the cycle of a repeated index across the whole window, with and without the halt flag on the reference. A successor or repeat placed before the trigger shows that earlier retirements are ignored. One placed on the final cycle shows that the verdict cycle itself counts. The reference index is varied, including all ones, to separate a wrapping successor from a plain increment. Directed runs cover a trigger with no valid retirement, a second trigger, a halt flag on a non-reference retirement and index matches hidden behind a low valid.

// File: rtl/retire_progress_checker.sv
module retire_progress_checker #(
  parameter int ORD_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trace_valid,
  input  logic [ORD_W-1:0] trace_order,
  input  logic             trace_halt,
  input  logic             trigger,
  input  logic             check,
  output logic             live_ok,
  output logic             uniq_ok
);

  logic             armed;
  logic [ORD_W-1:0] ref_order;
  logic             ref_halt;
  logic             seen_next;
  logic             dup_seen;

  logic [ORD_W-1:0] next_order;
  logic             hit_next;
  logic             hit_dup;
  logic             capture;

  assign next_order = ref_order + {{(ORD_W-1){1'b0}}, 1'b1};
  assign capture    = !armed && trigger && trace_valid;
  assign hit_next   = armed && trace_valid && (trace_order == next_order);
  assign hit_dup    = armed && trace_valid && (trace_order == ref_order);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      ref_order <= '0;
      ref_halt  <= 1'b0;
      seen_next <= 1'b0;
      dup_seen  <= 1'b0;
    end else begin
      if (capture) begin
        armed     <= 1'b1;
        ref_order <= trace_order;
        ref_halt  <= trace_halt;
      end
      if (hit_next) seen_next <= 1'b1;
      if (hit_dup)  dup_seen  <= 1'b1;
    end
  end

  assign live_ok = !(check && armed && !ref_halt && !seen_next && !hit_next);
  assign uniq_ok = !(dup_seen || hit_dup);

endmodule

// File: rtl/retire_progress_props.sv
module retire_progress_props #(
  parameter int ORD_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             check,
  input logic             armed,
  input logic [ORD_W-1:0] ref_order,
  input logic             ref_halt,
  input logic             live_ok,
  input logic             uniq_ok
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (live_ok && uniq_ok));

  p_ref_held_r2: assert property (@(posedge clk) disable iff (rst)
    armed |=> (armed && $stable(ref_order) && $stable(ref_halt)));

  p_halt_waives_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && ref_halt) |-> live_ok);

  p_idle_pass_r6: assert property (@(posedge clk) disable iff (rst)
    !check |-> live_ok);

  p_dup_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !uniq_ok |=> !uniq_ok);

  p_unarmed_pass_r9: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (live_ok && uniq_ok));

endmodule

bind retire_progress_checker retire_progress_props #(.ORD_W(ORD_W)) u_props (
  .clk       (clk),
  .rst       (rst),
  .check     (check),
  .armed     (armed),
  .ref_order (ref_order),
  .ref_halt  (ref_halt),
  .live_ok   (live_ok),
  .uniq_ok   (uniq_ok)
);

// File: tb/retire_progress_checker_test.sv
module retire_progress_checker_test;
  localparam int ORD_W = 64;
  localparam int WIN   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             trace_valid = 1'b0;
  logic [ORD_W-1:0] trace_order = '0;
  logic             trace_halt = 1'b0;
  logic             trigger = 1'b0;
  logic             check = 1'b0;
  logic             live_ok;
  logic             uniq_ok;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  retire_progress_checker #(.ORD_W(ORD_W)) uut (
    .clk(clk), .rst(rst), .trace_valid(trace_valid), .trace_order(trace_order),
    .trace_halt(trace_halt), .trigger(trigger), .check(check),
    .live_ok(live_ok), .uniq_ok(uniq_ok)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [ORD_W-1:0] o, input logic h,
                       input logic t, input logic c);
    @(negedge clk);
    trace_valid = v; trace_order = o; trace_halt = h; trigger = t; check = c;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; trace_valid = 0; trigger = 0; check = 0; trace_halt = 0;
    @(negedge clk);
    #1;
    chk("R1 live in reset", live_ok, 1'b1);
    chk("R1 uniq in reset", uniq_ok, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 live after reset", live_ok, 1'b1);
    chk("R1 uniq after reset", uniq_ok, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [ORD_W-1:0] kv [3];
    kv[0] = 64'd5;
    kv[1] = {ORD_W{1'b1}};
    kv[2] = 64'h7FFF_FFFF_FFFF_FFFF;

    for (int ki = 0; ki < 3; ki++) begin
      for (int ta = 0; ta < 4; ta++) begin
        for (int na = 0; na <= WIN; na++) begin
          for (int da = 0; da <= WIN; da++) begin
            for (int h = 0; h < 2; h++) begin
              logic [ORD_W-1:0] k;
              if (na == ta || da == ta || (da == na && na != WIN)) continue;
              k = kv[ki];
              do_reset();
              for (int c = 0; c < WIN; c++) begin
                logic [ORD_W-1:0] o;
                logic exp_live, exp_uniq, last;
                string lt, ut;
                last = (c == WIN - 1);
                if (c == ta) o = k;
                else if (c == na) o = k + 1;
                else if (c == da) o = k;
                else o = k + 64'd100 + 64'(c);
                drive(1'b1, o, (c == ta) ? h[0] : 1'b0, c == ta, last);
                exp_live = !last || (h == 1) || (na > ta && na < WIN);
                exp_uniq = !(da > ta && da < WIN && c >= da);
                if (!last) lt = "R6";
                else if (h == 1) lt = "R5";
                else if (exp_live) lt = (ki == 1) ? "R10 wrap" : ((na < ta) ? "R8" : "R3");
                else lt = (na < ta && na < WIN) ? "R8" : "R4";
                ut = (da < ta) ? "R8 early dup" : "R7";
                chk($sformatf("%s live k%0d t%0d n%0d d%0d h%0d c%0d", lt, ki, ta, na, da, h, c),
                    live_ok, exp_live);
                chk($sformatf("%s uniq k%0d t%0d n%0d d%0d c%0d", ut, ki, ta, na, da, c),
                    uniq_ok, exp_uniq);
              end
            end
          end
        end
      end
    end

    // R9: no trigger at all, repeated indices
    do_reset();
    drive(1, 64'd10, 0, 0, 0);
    drive(1, 64'd10, 0, 0, 0);
    drive(1, 64'd10, 0, 0, 1);
    chk("R9 live no trigger", live_ok, 1'b1);
    chk("R9 uniq no trigger", uniq_ok, 1'b1);

    // R2: trigger with valid low captures nothing
    do_reset();
    drive(0, 64'd20, 0, 1, 0);
    drive(1, 64'd20, 0, 0, 0);
    drive(1, 64'd20, 0, 0, 1);
    chk("R2 trigger without valid live", live_ok, 1'b1);
    chk("R2 trigger without valid uniq", uniq_ok, 1'b1);

    // R2: second trigger ignored
    do_reset();
    drive(1, 64'd30, 0, 1, 0);
    drive(1, 64'd50, 0, 1, 0);
    drive(1, 64'd50, 0, 0, 0);
    chk("R2 second trigger uniq", uniq_ok, 1'b1);
    drive(1, 64'd31, 0, 0, 1);
    chk("R2 second trigger live", live_ok, 1'b1);
    drive(0, 64'd0, 0, 0, 1);
    chk("R2 first reference kept", live_ok, 1'b1);

    // R5: halt on a non-reference retirement waives nothing
    do_reset();
    drive(1, 64'd40, 0, 1, 0);
    drive(1, 64'd77, 1, 0, 0);
    drive(0, 64'd0, 0, 0, 1);
    chk("R5 foreign halt live", live_ok, 1'b0);

    // R11: valid low hides matching indices
    do_reset();
    drive(1, 64'd60, 0, 1, 0);
    drive(0, 64'd60, 0, 0, 0);
    chk("R11 invalid dup uniq", uniq_ok, 1'b1);
    drive(0, 64'd61, 0, 0, 1);
    chk("R11 invalid next live", live_ok, 1'b0);
    chk("R11 invalid uniq", uniq_ok, 1'b1);

    // R7: sticky across many cycles
    do_reset();
    drive(1, 64'd70, 0, 1, 0);
    drive(1, 64'd70, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      drive(1, 64'd71, 0, 0, 0);
      chk("R7 sticky uniq", uniq_ok, 1'b0);
    end

    // R1: reset clears a latched failure
    do_reset();
    drive(0, 64'd0, 0, 0, 1);
    chk("R1 cleared uniq", uniq_ok, 1'b1);
    chk("R1 cleared live", live_ok, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule